// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block routes clock enables and gate levels to a bank of counter channels. The channels are arranged as three groups. Each group holds two timer devices, and each device has three channels, which gives eighteen channels in total. A host programs the routing over a simple byte-wide register bus. A single byte written to a group's clock-select or gate-select register carries the device, the channel and a 5-bit source code split across two fields. That one write updates the routing of one channel.

From the 20 MHz system clock the block builds internal timebases of 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. Each timebase is a single-cycle clock-enable pulse. For each channel the block holds the selected clock and gate sources and drives the chosen enable and gate level. In normal mode only source codes 0 to 7 are accepted. A separate enhance bit widens the range to 0 to 31 and makes a full-rate 20 MHz source available. The counters, the conditioning of the external pins and the host bridge are outside the block.

Top module: `ctr_route_top`

## Requirements
- R1: After reset, every channel has clock source 0 and gate source 0. Every `gate_out` bit is 1 and every `clk_en_out` bit follows its `ext_clk_in` bit.
- R2: Layout of a select byte:
  - bit 5 picks the device (0 or 1);
  - bits 4:3 pick the channel (0 to 2);
  - the source code is {bits 7:6, bits 2:0}.
  The targeted channel index is group*6 + device*3 + channel. No other channel changes.
- R3: Register addresses:
  - the clock-select registers of groups 0, 1 and 2 are at addresses 0, 1 and 2;
  - the gate-select registers of groups 0, 1 and 2 are at addresses 3, 4 and 5;
  - the enhance bit is bit 0 of address 6.
- R4: A select write whose channel field (bits 4:3) is 3 changes no channel.
- R5: While the enhance bit is 0, a select write with nonzero bits 7:6 changes no channel.
- R6: While the enhance bit is 1, source codes up to 31 are stored. Clock source 11 then drives `clk_en_out` high on every cycle.
- R7: Clock source 0 passes the channel's `ext_clk_in` bit to `clk_en_out` in the same cycle.
- R8: Clock sources 1 to 5 give single-cycle pulses with periods of 2, 20, 200, 2000 and 20000 system cycles. Every pulse of a slower timebase coincides with a pulse of the next faster one.
- R9: Gate source 0 drives 1 and every other gate code drives 0. The following clock codes drive 0: 6 to 10, 12 to 31, and any code of 8 or more while the enhance bit is 0.
- R10: A read at addresses 0 to 5 returns 0. A read at address 6 returns the enhance bit in bit 0. `rd_data` follows `addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Read data for `addr` |
| ext_clk_in | input | 18 | Dedicated external clock enable per channel |
| clk_en_out | output | 18 | Routed clock enable per channel |
| gate_out | output | 18 | Routed gate level per channel |

## Verification
Some properties are checked by assertions on every cycle:
- every timebase pulse lasts a single cycle, and each slower pulse lands on a faster one;
- the select registers always read 0;
- gate levels move only after a write;
- gate writes that are malformed or out of range for the current mode leave every gate untouched.

Other behaviour is shown only by the bench's directed scenarios:
- the exact timebase periods;
- the channel index a packed byte reaches;
- the full-rate source appearing and then vanishing as the enhance bit toggles;
- the reserved clock codes driving 0.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;
  localparam int SRC_W  = 5;
  localparam int NUM_TB = 5;

  typedef logic [SRC_W-1:0] src_t;

  // Clock-enable selection for one channel.
  function automatic logic clk_pick(input src_t s, input logic enh,
                                    input logic ext, input logic [NUM_TB-1:0] tb);
    logic r;
    r = 1'b0;
    if (enh || (s[4:3] == 2'b00)) begin
      case (s)
        5'd0:    r = ext;
        5'd1:    r = tb[0];
        5'd2:    r = tb[1];
        5'd3:    r = tb[2];
        5'd4:    r = tb[3];
        5'd5:    r = tb[4];
        5'd11:   r = 1'b1;
        default: r = 1'b0;
      endcase
    end
    return r;
  endfunction

  // Gate level selection for one channel.
  function automatic logic gate_pick(input src_t s);
    return (s == '0);
  endfunction
endpackage

// File: rtl/ctr_timebase.sv
module ctr_timebase #(
  parameter int PRE_DIV = 2,
  parameter int DEC     = 10,
  parameter int STAGES  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [STAGES:0] tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int DW = $clog2(DEC);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
  localparam logic [DW-1:0] DEC_LAST = DW'(DEC - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick[0] = (pre_q == PRE_LAST);

  for (genvar k = 0; k < STAGES; k++) begin : g_dec
    logic [DW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (tick[k]) cnt_d = (cnt_q == DEC_LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign tick[k+1] = tick[k] && (cnt_q == DEC_LAST);
  end
endmodule

// File: rtl/ctr_sel_regs.sv
module ctr_sel_regs
  import ctr_route_pkg::*;
#(
  parameter int N_GRP  = 3,
  parameter int N_DEV  = 2,
  parameter int N_CH   = 3,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    rd_data,
  output logic [N_GRP*N_DEV*N_CH-1:0][SRC_W-1:0] clk_sel,
  output logic [N_GRP*N_DEV*N_CH-1:0][SRC_W-1:0] gate_sel,
  output logic                          enh
);
  localparam int NCH       = N_GRP * N_DEV * N_CH;
  localparam int GATE_BASE = N_GRP;
  localparam int ENH_ADDR  = 2 * N_GRP;

  logic [NCH-1:0][SRC_W-1:0] clk_q, clk_d, gate_q, gate_d;
  logic enh_q, enh_d;
  src_t wr_src;
  logic wr_ok, hit_clk, hit_gate;
  int   a_int, grp, wr_idx;

  always_comb begin
    a_int    = int'(addr);
    wr_src   = {wdata[7:6], wdata[2:0]};
    hit_clk  = (a_int < GATE_BASE);
    hit_gate = (a_int >= GATE_BASE) && (a_int < ENH_ADDR);
    grp      = hit_clk ? a_int : a_int - GATE_BASE;
    wr_ok    = (int'(wdata[4:3]) < N_CH) && (int'(wdata[5]) < N_DEV) &&
               (enh_q || (wdata[7:6] == 2'b00));
    wr_idx   = grp * N_DEV * N_CH + int'(wdata[5]) * N_CH + int'(wdata[4:3]);
  end

  always_comb begin
    clk_d  = clk_q;
    gate_d = gate_q;
    enh_d  = enh_q;
    if (wr_en) begin
      if (a_int == ENH_ADDR) enh_d = wdata[0];
      for (int i = 0; i < NCH; i++) begin
        if (wr_ok && (i == wr_idx)) begin
          if (hit_clk)  clk_d[i]  = wr_src;
          if (hit_gate) gate_d[i] = wr_src;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= '0;
      gate_q <= '0;
      enh_q  <= 1'b0;
    end else begin
      clk_q  <= clk_d;
      gate_q <= gate_d;
      enh_q  <= enh_d;
    end
  end

  assign rd_data  = (a_int == ENH_ADDR) ? {7'b0, enh_q} : 8'h00;
  assign clk_sel  = clk_q;
  assign gate_sel = gate_q;
  assign enh      = enh_q;
endmodule

// File: rtl/ctr_src_mux.sv
module ctr_src_mux
  import ctr_route_pkg::*;
#(
  parameter int NCH = 18
) (
  input  logic [NCH-1:0][SRC_W-1:0] clk_sel,
  input  logic [NCH-1:0][SRC_W-1:0] gate_sel,
  input  logic                      enh,
  input  logic [NCH-1:0]            ext_clk,
  input  logic [NUM_TB-1:0]         tick,
  output logic [NCH-1:0]            clk_en,
  output logic [NCH-1:0]            gate
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      clk_en[i] = clk_pick(clk_sel[i], enh, ext_clk[i], tick);
      gate[i]   = gate_pick(gate_sel[i]);
    end
  end
endmodule

// File: rtl/ctr_route_top.sv
module ctr_route_top
  import ctr_route_pkg::*;
#(
  parameter int N_GRP   = 3,
  parameter int N_DEV   = 2,
  parameter int N_CH    = 3,
  parameter int ADDR_W  = 3,
  parameter int PRE_DIV = 2,
  parameter int DEC     = 10,
  parameter int NCH     = N_GRP * N_DEV * N_CH
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  input  logic [NCH-1:0]    ext_clk_in,
  output logic [NCH-1:0]    clk_en_out,
  output logic [NCH-1:0]    gate_out
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [NUM_TB-1:0]         tb_tick;
  logic [NCH-1:0][SRC_W-1:0] clk_sel, gate_sel;
  logic                      enh_q;

  ctr_timebase #(.PRE_DIV(PRE_DIV), .DEC(DEC), .STAGES(NUM_TB-1)) u_timebase (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tb_tick)
  );

  ctr_sel_regs #(.N_GRP(N_GRP), .N_DEV(N_DEV), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_data (rd_data),
    .clk_sel (clk_sel),
    .gate_sel(gate_sel),
    .enh     (enh_q)
  );

  ctr_src_mux #(.NCH(NCH)) u_mux (
    .clk_sel (clk_sel),
    .gate_sel(gate_sel),
    .enh     (enh_q),
    .ext_clk (ext_clk_in),
    .tick    (tb_tick),
    .clk_en  (clk_en_out),
    .gate    (gate_out)
  );
endmodule

// File: rtl/ctr_route_chk.sv
module ctr_route_chk
  import ctr_route_pkg::*;
#(
  parameter int N_GRP  = 3,
  parameter int ADDR_W = 3,
  parameter int NCH    = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rd_data,
  input logic [NCH-1:0]    gate_out,
  input logic [NUM_TB-1:0] tick,
  input logic              enh
);
  for (genvar k = 0; k < NUM_TB; k++) begin : g_single
    // R8: each timebase pulse lasts exactly one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tick[k] |=> !tick[k]);
  end

  for (genvar k = 1; k < NUM_TB; k++) begin : g_nest
    // R8: a slower pulse always lands on a faster one
    a_r8_nested_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tick[k] |-> tick[k-1]);
  end

  // R10: select registers read as zero
  a_r10_sel_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) < 2 * N_GRP) |-> (rd_data == 8'h00));

  // R2: gate levels only move after a write
  a_r2_gate_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(gate_out));

  // R4: channel field 3 is dropped
  a_r4_bad_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[4:3] == 2'b11) |=> $stable(gate_out));

  // R5: high source bits rejected in normal mode
  a_r5_normal_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !enh && wdata[7:6] != 2'b00) |=> $stable(gate_out));
endmodule

bind ctr_route_top ctr_route_chk #(.N_GRP(N_GRP), .ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rd_data (rd_data),
  .gate_out(gate_out),
  .tick    (tb_tick),
  .enh     (enh_q)
);

// File: tb/ctr_route_top_tb.sv
module ctr_route_top_tb;
  localparam int NCH = 18;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic            wr_en;
  logic [2:0]      addr;
  logic [7:0]      wdata;
  logic [7:0]      rd_data;
  logic [NCH-1:0]  ext_clk_in;
  logic [NCH-1:0]  clk_en_out;
  logic [NCH-1:0]  gate_out;

  int checks = 0;
  int errors = 0;
  logic [NCH-1:0] gate_exp;

  always #2.5 clk = ~clk;

  ctr_route_top u_dut (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rd_data   (rd_data),
    .ext_clk_in(ext_clk_in),
    .clk_en_out(clk_en_out),
    .gate_out  (gate_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd7;
    #1;
  endtask

  task automatic t_reset;
    chk("R1", "gates after reset", 32'(gate_out), 32'h3FFFF);
    ext_clk_in = 18'h2A5C3;
    #1;
    chk("R1", "clock follows ext", 32'(clk_en_out), 32'h2A5C3);
    ext_clk_in = 18'h15A3C;
    #1;
    chk("R7", "ext passthrough same cycle", 32'(clk_en_out), 32'h15A3C);
  endtask

  task automatic t_decode;
    ext_clk_in = '1;
    wr(3'd1, 8'h36);  // group1 dev1 ch2 src6 -> index 11
    chk("R2", "only channel 11 moved", 32'(clk_en_out), 32'h3FFFF & ~(32'h1 << 11));
    wr(3'd3, 8'h0B);  // gate group0 dev0 ch1 src3 -> index 1
    wr(3'd4, 8'h01);  // gate group1 dev0 ch0 src1 -> index 6
    gate_exp = 18'h3FFFF & ~18'h00042;
    chk("R3", "gate group addressing", 32'(gate_out), 32'(gate_exp));
    chk("R9", "nonzero gate code low", 32'(gate_out[6]), 32'h0);
    wr(3'd1, 8'h32);  // back to 1MHz timebase, used below as harmless
    wr(3'd1, 8'h30);  // back to source 0
    chk("R2", "restore channel 11", 32'(clk_en_out), 32'h3FFFF);
  endtask

  task automatic t_periods;
    int last [5];
    int first [5];
    logic prev [5];
    int exp_p [5] = '{2, 20, 200, 2000, 20000};
    int width_bad = 0;
    ext_clk_in = '0;
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h0A);
    wr(3'd0, 8'h13);
    wr(3'd0, 8'h24);
    wr(3'd0, 8'h2D);
    for (int c = 0; c < 5; c++) begin last[c] = -1; first[c] = -1; prev[c] = 1'b0; end
    for (int n = 0; n < 45000; n++) begin
      @(negedge clk); #1;
      for (int c = 0; c < 5; c++) begin
        if (clk_en_out[c]) begin
          if (prev[c] && c > 0) width_bad++;
          if (last[c] >= 0 && first[c] < 0) first[c] = n - last[c];
          last[c] = n;
        end
        prev[c] = clk_en_out[c];
      end
    end
    for (int c = 0; c < 5; c++)
      chk("R8", $sformatf("period of source %0d", c + 1), 32'(first[c]), 32'(exp_p[c]));
    chk("R8", "single-cycle pulses", 32'(width_bad), 32'h0);
  endtask

  task automatic t_bad_channel;
    wr(3'd5, 8'h19);  // channel field 3
    chk("R4", "channel 3 write ignored", 32'(gate_out), 32'(gate_exp));
  endtask

  task automatic t_modes;
    wr(3'd5, 8'h40);  // src 8, normal mode
    chk("R5", "high bits ignored in normal mode", 32'(gate_out), 32'(gate_exp));
    wr(3'd6, 8'h01);
    wr(3'd5, 8'h40);
    gate_exp[12] = 1'b0;
    chk("R6", "enhanced accepts code 8", 32'(gate_out), 32'(gate_exp));
    wr(3'd5, 8'h00);
    gate_exp[12] = 1'b1;
    chk("R9", "gate code 0 high", 32'(gate_out), 32'(gate_exp));
  endtask

  task automatic t_fullrate;
    int hi = 0;
    wr(3'd2, 8'h63);  // group2 dev1 ch0 src11 -> index 15
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); #1;
      if (clk_en_out[15]) hi++;
    end
    chk("R6", "source 11 every cycle", 32'(hi), 32'd8);
    wr(3'd2, 8'h64);  // src 12
    chk("R9", "reserved code 12 low", 32'(clk_en_out[15]), 32'h0);
    wr(3'd2, 8'h26);  // src 6
    chk("R9", "reserved code 6 low", 32'(clk_en_out[15]), 32'h0);
    wr(3'd2, 8'h63);
    wr(3'd6, 8'h00);
    hi = 0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); #1;
      if (clk_en_out[15]) hi++;
    end
    chk("R9", "code 11 dead when enhance cleared", 32'(hi), 32'd0);
  endtask

  task automatic t_reads;
    for (int a = 0; a < 6; a++) begin
      @(negedge clk); addr = 3'(a); #1;
      chk("R10", $sformatf("select read at %0d", a), 32'(rd_data), 32'h0);
    end
    @(negedge clk); addr = 3'd6; #1;
    chk("R10", "enhance read cleared", 32'(rd_data), 32'h0);
    wr(3'd6, 8'h01);
    addr = 3'd6; #1;
    chk("R10", "enhance read set", 32'(rd_data), 32'h1);
  endtask

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_en = 1'b0; addr = 3'd7; wdata = 8'h00; ext_clk_in = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_decode();
    t_periods();
    t_bad_channel();
    t_modes();
    t_fullrate();
    t_reads();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule